// File: doc/BRIEF.md
# Ethernet PHY Control Register with MAC-Side Gating

This block holds the basic control word of an Ethernet PHY: auto-negotiation enable, low-power mode, isolation and an auto-negotiation restart request. It also turns the low-power and isolate settings straight into the enable and force controls for the pins that face the MAC.

A management agent reaches the word through a simple port. One address bus is shared by reads and writes. A write is qualified by a write strobe and the read data is combinational. Outside this block, every MAC-facing output pin has its own output enable and its own force-low control, and the MAC-facing input pins have a single ignore control. The line transmitter has a tristate control. Two single-cycle strobes go out of the block:

- one asks the auto-negotiation engine to restart;
- one asks the status logic to return its latching-high and latching-low bits to their defaults.

A strobe from the auto-negotiation engine, saying that negotiation has started, clears the restart request.

Top module: `phy_ctrl_reg`

## Requirements
- R1: While reset is active, and after it is released, the control word reads with auto-negotiation enable (bit 12) = 1, low power (bit 11) = 0 and restart (bit 9) = 0. Bits 15..13 and 8..0 always read 0 and ignore writes. Any address other than the control address (default 0) reads 0.
- R2: After reset, isolate (bit 10) reads 1 when the strapped PHY address is 5'b00000, and reads 0 for any other strap value.
- R3: A write to the control address loads bits 12, 11 and 10 from the write data, and the new values read back from the next cycle. Reads and writes work normally while isolate or low power is set.
- R4: While isolate is 1, every MAC output enable is 0, every force-low is 0 and the input-ignore control is 1, whatever low power is. Output index order: 0 transmit clock, 1 receive clock, 2 receive valid, 3 receive error, 4..7 receive data 0..3, 8 collision, 9 carrier sense.
- R5: While low power is 1 and isolate is 0, every MAC output enable is 1, every force-low is 1 and input-ignore is 1. The line-transmit tristate equals the low-power bit, whatever isolate is.
- R6: With both bits 0, every output enable is 1, every force-low is 0, and input-ignore and line tristate are 0.
- R7: The latching-status clear output is 1 for exactly one cycle: the first cycle in which low power reads 1 after reading 0. It stays 0 while low power remains 1, including when 1 is written again.
- R8: A write with bit 9 = 1 is accepted only when the software-mode input is 1 and the written bit 12 is 1. On acceptance, bit 9 reads 1 and the restart output is 1 for one cycle, both starting the next cycle.
- R9: A write of 1 to bit 9 with software mode 0, or with bit 12 written 0, leaves bit 9 at 0 and gives no restart pulse. A write with bit 12 = 0 clears a pending bit 9.
- R10: Bit 9 reads 0 in the cycle after the negotiation-started strobe. Writing 0 to bit 9 does not clear it. If an accepted write and the strobe fall in the same cycle, the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| strap_phy_addr | input | 5 | Strapped PHY address, static |
| sw_mode | input | 1 | 1 = software mode, restart writes honoured |
| reg_addr | input | ADDR_W | Register address for read and write |
| reg_wr_en | input | 1 | Write strobe |
| reg_wr_data | input | 16 | Write data |
| reg_rd_data | output | 16 | Combinational read data |
| an_started | input | 1 | Auto-negotiation has begun (one-cycle strobe) |
| an_restart | output | 1 | One-cycle restart request |
| lat_clr | output | 1 | One-cycle request to reinitialise latching status bits |
| mac_oe | output | MAC_OUT_N | Per-pin MAC output enable |
| mac_force_low | output | MAC_OUT_N | Per-pin MAC output force-low |
| mac_in_ignore | output | 1 | Ignore MAC-side inputs |
| line_tx_tri | output | 1 | Tristate the twisted-pair transmitter |

## Verification
The properties assume that the strapped PHY address holds still while reset is released. The bench only changes the strap while reset is asserted. The properties also assume that the negotiation-started strobe is a plain input with no ordering rule against writes. The bench therefore drives it alone, and also together with an accepted write, to cover the priority between the two. All inputs change half a period away from the active clock edge, so every write lands in exactly one cycle.

// File: rtl/phy_ctrl_pkg.sv
package phy_ctrl_pkg;
  localparam int unsigned REG_W      = 16;
  localparam int unsigned B_AN_EN    = 12;
  localparam int unsigned B_LOW_PWR  = 11;
  localparam int unsigned B_ISOLATE  = 10;
  localparam int unsigned B_RESTART  = 9;
  localparam int unsigned STRAP_W    = 5;

  typedef struct packed {
    logic an_en;
    logic low_pwr;
    logic isolate;
    logic restart;
  } ctrl_bits_t;
endpackage

// File: rtl/phy_rst_sync.sv
module phy_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/phy_ctrl_regs.sv
module phy_ctrl_regs
  import phy_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned CTRL_ADDR = 0,
  parameter bit          AN_EN_RST = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iso_dflt,
  input  logic              sw_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [3:0]        wr_bits,   // written bits 12..9
  input  logic              an_started,
  output ctrl_bits_t        ctrl,
  output logic [REG_W-1:0]  rd_data,
  output logic              an_restart,
  output logic              lat_clr
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  logic an_en_q, an_en_d;
  logic lp_q, lp_d;
  logic iso_x_q, iso_x_d;       // isolate stored relative to its strap default
  logic rst_q, rst_d;
  logic pulse_q, pulse_d;
  logic clr_q, clr_d;
  logic hit, accept, cfg_ce;

  always_comb begin
    hit     = wr_en && (addr == CTRL_A);
    accept  = hit && sw_mode && wr_bits[3] && wr_bits[0];
    cfg_ce  = hit;
    an_en_d = wr_bits[3];
    lp_d    = wr_bits[2];
    iso_x_d = wr_bits[1] ^ iso_dflt;
    rst_d   = rst_q;
    if (accept)                  rst_d = 1'b1;
    else if (hit && !wr_bits[3]) rst_d = 1'b0;
    else if (an_started)         rst_d = 1'b0;
    pulse_d = accept;
    clr_d   = (cfg_ce ? lp_d : lp_q) && !lp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      an_en_q <= AN_EN_RST;
      lp_q    <= 1'b0;
      iso_x_q <= 1'b0;
    end else if (cfg_ce) begin
      an_en_q <= an_en_d;
      lp_q    <= lp_d;
      iso_x_q <= iso_x_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q   <= 1'b0;
      pulse_q <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      rst_q   <= rst_d;
      pulse_q <= pulse_d;
      clr_q   <= clr_d;
    end
  end

  assign ctrl.an_en   = an_en_q;
  assign ctrl.low_pwr = lp_q;
  assign ctrl.isolate = iso_x_q ^ iso_dflt;
  assign ctrl.restart = rst_q;
  assign an_restart   = pulse_q;
  assign lat_clr      = clr_q;

  always_comb begin
    rd_data = '0;
    if (addr == CTRL_A) begin
      rd_data[B_AN_EN]   = ctrl.an_en;
      rd_data[B_LOW_PWR] = ctrl.low_pwr;
      rd_data[B_ISOLATE] = ctrl.isolate;
      rd_data[B_RESTART] = ctrl.restart;
    end
  end
endmodule

// File: rtl/phy_mac_gate.sv
module phy_mac_gate #(
  parameter int unsigned MAC_OUT_N = 10
) (
  input  logic                 isolate,
  input  logic                 low_pwr,
  output logic [MAC_OUT_N-1:0] oe,
  output logic [MAC_OUT_N-1:0] force_low,
  output logic                 in_ignore,
  output logic                 line_tri
);
  for (genvar i = 0; i < MAC_OUT_N; i++) begin : g_pin
    assign oe[i]        = !isolate;
    assign force_low[i] = low_pwr && !isolate;
  end
  assign in_ignore = isolate || low_pwr;
  assign line_tri  = low_pwr;
endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
  import phy_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned MAC_OUT_N = 10,
  parameter bit          AN_EN_RST = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [STRAP_W-1:0]   strap_phy_addr,
  input  logic                 sw_mode,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wr_en,
  input  logic [REG_W-1:0]     reg_wr_data,
  output logic [REG_W-1:0]     reg_rd_data,
  input  logic                 an_started,
  output logic                 an_restart,
  output logic                 lat_clr,
  output logic [MAC_OUT_N-1:0] mac_oe,
  output logic [MAC_OUT_N-1:0] mac_force_low,
  output logic                 mac_in_ignore,
  output logic                 line_tx_tri
);
  logic       rst_s_n;
  logic       iso_dflt;
  ctrl_bits_t ctrl;
  logic       iso_bit, lp_bit, an_en_bit, restart_bit;

  assign iso_dflt = (strap_phy_addr == '0);

  phy_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s_n)
  );

  phy_ctrl_regs #(
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR),
    .AN_EN_RST (AN_EN_RST)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .iso_dflt   (iso_dflt),
    .sw_mode    (sw_mode),
    .addr       (reg_addr),
    .wr_en      (reg_wr_en),
    .wr_bits    (reg_wr_data[B_AN_EN:B_RESTART]),
    .an_started (an_started),
    .ctrl       (ctrl),
    .rd_data    (reg_rd_data),
    .an_restart (an_restart),
    .lat_clr    (lat_clr)
  );

  assign iso_bit     = ctrl.isolate;
  assign lp_bit      = ctrl.low_pwr;
  assign an_en_bit   = ctrl.an_en;
  assign restart_bit = ctrl.restart;

  phy_mac_gate #(.MAC_OUT_N(MAC_OUT_N)) u_gate (
    .isolate   (iso_bit),
    .low_pwr   (lp_bit),
    .oe        (mac_oe),
    .force_low (mac_force_low),
    .in_ignore (mac_in_ignore),
    .line_tri  (line_tx_tri)
  );
endmodule

// File: rtl/phy_ctrl_reg_chk.sv
module phy_ctrl_reg_chk #(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned MAC_OUT_N = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sw_mode,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic                 reg_wr_en,
  input logic [15:0]          reg_wr_data,
  input logic                 an_started,
  input logic                 an_restart,
  input logic                 lat_clr,
  input logic [MAC_OUT_N-1:0] mac_oe,
  input logic [MAC_OUT_N-1:0] mac_force_low,
  input logic                 mac_in_ignore,
  input logic                 line_tx_tri,
  input logic                 iso_bit,
  input logic                 lp_bit,
  input logic                 an_en_bit,
  input logic                 restart_bit
);
  logic acc_wr;
  assign acc_wr = reg_wr_en && (reg_addr == ADDR_W'(CTRL_ADDR)) && sw_mode
                  && reg_wr_data[12] && reg_wr_data[9];

  p_isolate_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    iso_bit |-> (mac_oe == '0) && (mac_force_low == '0) && mac_in_ignore);

  p_lowpwr_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_bit && !iso_bit) |-> (&mac_oe) && (&mac_force_low) && mac_in_ignore && line_tx_tri);

  p_normal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lp_bit |-> (mac_force_low == '0) && !line_tx_tri);

  p_clr_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lat_clr |-> lp_bit && !$past(lp_bit));

  p_clr_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lat_clr |=> !lat_clr);

  p_restart_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    an_restart |-> restart_bit && $past(acc_wr));

  p_restart_needs_an_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart_bit |-> an_en_bit);

  p_self_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(an_started && !acc_wr) |-> !restart_bit);
endmodule

bind phy_ctrl_reg phy_ctrl_reg_chk #(
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .MAC_OUT_N(MAC_OUT_N)
) u_chk (
  .clk(clk), .rst_n(rst_s_n), .sw_mode(sw_mode), .reg_addr(reg_addr),
  .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .an_started(an_started),
  .an_restart(an_restart), .lat_clr(lat_clr), .mac_oe(mac_oe),
  .mac_force_low(mac_force_low), .mac_in_ignore(mac_in_ignore),
  .line_tx_tri(line_tx_tri), .iso_bit(iso_bit), .lp_bit(lp_bit),
  .an_en_bit(an_en_bit), .restart_bit(restart_bit)
);

// File: tb/phy_ctrl_reg_bench.sv
`timescale 1ns/1ps
module phy_ctrl_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  strap;
  logic        sw_mode;
  logic [4:0]  reg_addr;
  logic        reg_wr_en;
  logic [15:0] reg_wr_data;
  logic [15:0] reg_rd_data;
  logic        an_started;
  logic        an_restart;
  logic        lat_clr;
  logic [9:0]  mac_oe;
  logic [9:0]  mac_force_low;
  logic        mac_in_ignore;
  logic        line_tx_tri;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  phy_ctrl_reg u_phy_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .strap_phy_addr(strap), .sw_mode(sw_mode),
    .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .an_started(an_started), .an_restart(an_restart),
    .lat_clr(lat_clr), .mac_oe(mac_oe), .mac_force_low(mac_force_low),
    .mac_in_ignore(mac_in_ignore), .line_tx_tri(line_tx_tri)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // gating view: {oe, force_low, ignore, tri}
  function automatic logic [31:0] gate_view();
    return {10'b0, mac_oe, mac_force_low, mac_in_ignore, line_tx_tri};
  endfunction
  function automatic logic [31:0] gv(input logic oe, input logic fl, input logic ig, input logic tr);
    return {10'b0, {10{oe}}, {10{fl}}, ig, tr};
  endfunction

  task automatic wr(input logic [15:0] d, input logic strobe = 1'b0);
    @(negedge clk);
    reg_addr = 5'd0; reg_wr_en = 1'b1; reg_wr_data = d; an_started = strobe;
    @(negedge clk);
    reg_wr_en = 1'b0; an_started = 1'b0;
  endtask

  task automatic rd_ctrl(input string tag, input logic [15:0] exp);
    reg_addr = 5'd0; #0.5;
    chk(tag, {16'b0, reg_rd_data}, {16'b0, exp});
  endtask

  task automatic t_reset(input logic [4:0] s, input logic [15:0] exp_rd);
    @(negedge clk);
    rst_n = 1'b0; strap = s;
    #0.5;
    rd_ctrl("R1 R2 value during reset", exp_rd);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_ctrl("R1 R2 value after reset", exp_rd);
    chk("R4 R6 gating after reset", gate_view(),
        exp_rd[10] ? gv(0, 0, 1, 0) : gv(1, 0, 0, 0));
    chk("R1 lat_clr idle", {31'b0, lat_clr}, 0);
    reg_addr = 5'd5; #0.5;
    chk("R1 other address reads 0", {16'b0, reg_rd_data}, 0);
  endtask

  task automatic t_gating();
    sw_mode = 1'b0;
    wr(16'hFFFF);
    chk("R7 clear on low-power rise", {31'b0, lat_clr}, 1);
    rd_ctrl("R3 R1 R9 write all ones", 16'h1C00);
    chk("R4 R5 isolate wins, line tristated", gate_view(), gv(0, 0, 1, 1));
    @(negedge clk);
    chk("R7 clear lasts one cycle", {31'b0, lat_clr}, 0);
    wr(16'h1800);
    chk("R7 no clear on rewrite of 1", {31'b0, lat_clr}, 0);
    rd_ctrl("R3 low power only", 16'h1800);
    chk("R5 low power drives low", gate_view(), gv(1, 1, 1, 1));
    wr(16'h1000);
    rd_ctrl("R3 both cleared", 16'h1000);
    chk("R6 normal gating", gate_view(), gv(1, 0, 0, 0));
    wr(16'h1400);
    chk("R4 isolate only", gate_view(), gv(0, 0, 1, 0));
    wr(16'h1000);
  endtask

  task automatic t_restart();
    sw_mode = 1'b1;
    wr(16'h1200);
    chk("R8 restart pulse", {31'b0, an_restart}, 1);
    rd_ctrl("R8 restart bit set", 16'h1200);
    @(negedge clk);
    chk("R8 pulse one cycle", {31'b0, an_restart}, 0);
    wr(16'h1000);
    rd_ctrl("R10 write 0 keeps bit", 16'h1200);
    @(negedge clk); an_started = 1'b1;
    @(negedge clk); an_started = 1'b0;
    rd_ctrl("R10 cleared after started", 16'h1000);
    wr(16'h0200);
    chk("R9 no pulse, AN disabled", {31'b0, an_restart}, 0);
    rd_ctrl("R9 blocked with AN off", 16'h0000);
    sw_mode = 1'b0;
    wr(16'h1200);
    chk("R9 no pulse, hardware mode", {31'b0, an_restart}, 0);
    rd_ctrl("R9 blocked in hardware mode", 16'h1000);
    sw_mode = 1'b1;
    wr(16'h1200, 1'b1);
    rd_ctrl("R10 write beats started strobe", 16'h1200);
    wr(16'h0000);
    rd_ctrl("R9 AN off clears pending", 16'h0000);
  endtask

  initial begin
    rst_n = 1'b0; strap = 5'd3; sw_mode = 1'b0; reg_addr = 5'd0;
    reg_wr_en = 1'b0; reg_wr_data = 16'h0; an_started = 1'b0;
    t_reset(5'd3, 16'h1000);
    t_reset(5'd0, 16'h1400);
    t_reset(5'd7, 16'h1000);
    t_gating();
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5.0);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule